// File: doc/BRIEF.md
# Two-Phase Interleaved PWM with Dithered Period

This block drives the two switches of an interleaved boost stage. Both phases share one switching period. The second phase counts half a period ahead of the first, so the two gates switch 180 degrees apart. Each phase has its own duty input. For each phase the block also emits a one-cycle sample strobe at the centre of that phase's on-time, so that an ADC samples the average inductor current with no software involved.

The period is not fixed. A base period comes in, typically moved by a load-dependent outer loop. The block scales that base by a dither factor in 2.14 fixed point, where 16384 means 1.0. When dithering is enabled, the factor sweeps as a triangle between about 0.9 and 1.1 of nominal, in fixed steps, and moves one step at every period boundary. This spreads the switching spectrum.

The base period and both duty inputs are captured only at a period boundary, so a pulse is never cut short. A controller FSM has two states. In **IDLE** all outputs are low, the factor is parked at nominal, and the scaled period is re-evaluated on every cycle. In **RUN** the period counter runs. There are two transitions:
- **IDLE→RUN**: the scaled period is at least 2.
- **RUN→IDLE**: at a boundary, the new scaled period is below 2.

A second FSM, in the dither generator, has the states **SWEEP_UP** and **SWEEP_DOWN**. It goes from up to down when it clamps at the maximum factor, and from down to up when it clamps at the minimum factor.

Top module: `ilv_pwm_dither`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four outputs are low. The dither factor starts at 16384.
- R2: In RUN, phase A's counter runs from 0 to P−1, where P is the latched period. gate_a is high exactly while that counter is below phase A's latched duty.
- R3: Phase B's count is (phase A count + floor(P/2)) mod P. gate_b is high exactly while that count is below phase B's latched duty.
- R4: trig_a, and likewise trig_b, is high for the single cycle in which that phase's count equals its latched duty shifted right by one, provided that duty is non-zero. A strobe always falls inside the on-time of its phase.
- R5: The period latched at a load is floor(base_period × F / 16384), where F is the dither factor for that period. For example, base 100 with F = 16630 gives 101, and with F = 16876 gives 103.
- R6: With jitter_en high, F changes by 246 at each period boundary. It rises until it clamps at 18021, then falls until it clamps at 14745, then rises again. F never leaves the range 14745..18021.
- R7: With jitter_en low at a boundary, the following period uses F = 16384, so P equals base_period.
- R8: A change of base_period, duty_a or duty_b in the middle of a period has no effect until the next period boundary.
- R9: A latched duty of zero gives no gate pulse and no strobe for that phase.
- R10: A duty at or above the new period is limited to P−1. The gate is then low for exactly one cycle per period, and the strobe still fires.
- R11: When the scaled period is below 2, the block sits in IDLE with all outputs low. It resumes once the scaled period is 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_period | input | CNT_W | Nominal period in clock cycles, before dithering |
| duty_a | input | CNT_W | On-time of phase A in clock cycles |
| duty_b | input | CNT_W | On-time of phase B in clock cycles |
| jitter_en | input | 1 | Enables the triangular sweep of the period |
| gate_a | output | 1 | Switch drive, phase A |
| gate_b | output | 1 | Switch drive, phase B (half a period later) |
| trig_a | output | 1 | Mid-on-time ADC start, phase A |
| trig_b | output | 1 | Mid-on-time ADC start, phase B |

## Verification
Fixed-base runs with dithering off separate a correct period scaling from an off-by-one in the counter wrap. The first dithered periods (101, then 103 for a base of 100) and the extremes of a full sweep (89 and 109) expose errors in step size, clamping and turn-around. Directed duty patterns cover the remaining corners: zero, at or above the period, and changed mid-period. Each of these tells apart correct shadow loading and clamping from direct use of the live inputs. A long random mix of bases (including 0 and 1), duties and enable toggles, compared cycle by cycle against a bench model, catches phase-B wrap errors and strobe placement at odd and even duties.

// File: rtl/ilv_pwm_pkg.sv
package ilv_pwm_pkg;

    // Controller state: counting or parked with outputs low
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Direction of the dither sweep
    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    // Number of interleaved phases
    localparam int unsigned NUM_PHASES = 2;

endpackage

// File: rtl/ilv_jitter_gen.sv
module ilv_jitter_gen
    import ilv_pwm_pkg::*;
#(
    parameter int unsigned FW       = 16,
    parameter int unsigned FAC_NOM  = 16384,
    parameter int unsigned FAC_MIN  = 14745,
    parameter int unsigned FAC_MAX  = 18021,
    parameter int unsigned FAC_STEP = 246
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          park,
    input  logic          adv,
    input  logic          en,
    output logic [FW-1:0] fac_nxt,
    output logic [FW-1:0] fac
);

    localparam logic [FW-1:0] NOM_V     = FW'(FAC_NOM);
    localparam logic [FW-1:0] MIN_V     = FW'(FAC_MIN);
    localparam logic [FW-1:0] MAX_V     = FW'(FAC_MAX);
    localparam logic [FW-1:0] STEP_V    = FW'(FAC_STEP);
    localparam logic [FW-1:0] LOW_EDGE  = FW'(FAC_MIN + FAC_STEP);
    localparam logic [FW:0]   MAX_WIDE  = (FW+1)'(FAC_MAX);

    sweep_dir_e    dir_q, dir_d;
    logic [FW-1:0] fac_q, fac_d;
    logic [FW:0]   up_sum;

    assign up_sum = {1'b0, fac_q} + {1'b0, STEP_V};

    // Next-state and next-factor logic for the sweep
    always_comb begin
        fac_d = fac_q;
        dir_d = dir_q;
        if (park) begin
            fac_d = NOM_V;
            dir_d = SWEEP_UP;
        end else if (adv) begin
            if (!en) begin
                fac_d = NOM_V;
                dir_d = SWEEP_UP;
            end else begin
                unique case (dir_q)
                    SWEEP_UP: begin
                        if (up_sum >= MAX_WIDE) begin
                            fac_d = MAX_V;
                            dir_d = SWEEP_DOWN;
                        end else begin
                            fac_d = up_sum[FW-1:0];
                        end
                    end
                    SWEEP_DOWN: begin
                        if (fac_q <= LOW_EDGE) begin
                            fac_d = MIN_V;
                            dir_d = SWEEP_UP;
                        end else begin
                            fac_d = fac_q - STEP_V;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= SWEEP_UP;
            fac_q <= NOM_V;
        end else begin
            dir_q <= dir_d;
            fac_q <= fac_d;
        end
    end

    // Outputs
    always_comb begin
        fac_nxt = fac_d;
        fac     = fac_q;
    end

endmodule

// File: rtl/ilv_period_calc.sv
module ilv_period_calc
    import ilv_pwm_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned FW      = 16,
    parameter int unsigned FRAC_SH = 14
) (
    input  logic [CNT_W-1:0]                  base,
    input  logic [FW-1:0]                     fac,
    input  logic [NUM_PHASES-1:0][CNT_W-1:0]  duty_in,
    output logic [CNT_W:0]                    per,
    output logic [NUM_PHASES-1:0][CNT_W:0]    duty_lim,
    output logic                              per_ok
);

    localparam int unsigned PW  = CNT_W + 1;
    localparam int unsigned PRW = CNT_W + FW;

    logic [PRW-1:0] prod;

    always_comb begin
        prod   = PRW'(base) * PRW'(fac);
        per    = PW'(prod >> FRAC_SH);
        per_ok = (per >= PW'(2));
    end

    // Duty limiting, one instance of the rule per phase
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_clamp
        always_comb begin
            if ({1'b0, duty_in[p]} >= per) begin
                duty_lim[p] = per - PW'(1);
            end else begin
                duty_lim[p] = {1'b0, duty_in[p]};
            end
        end
    end

endmodule

// File: rtl/ilv_phase_out.sv
module ilv_phase_out #(
    parameter int unsigned PW = 17
) (
    input  logic          run,
    input  logic [PW-1:0] cnt,
    input  logic [PW-1:0] duty,
    output logic          gate,
    output logic          trig
);

    logic [PW-1:0] mid;

    always_comb begin
        mid  = duty >> 1;
        gate = run && (cnt < duty);
        trig = run && (duty != '0) && (cnt == mid);
    end

endmodule

// File: rtl/ilv_pwm_dither.sv
module ilv_pwm_dither
    import ilv_pwm_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned FW       = 16,
    parameter int unsigned FRAC_SH  = 14,
    parameter int unsigned FAC_NOM  = 16384,
    parameter int unsigned FAC_MIN  = 14745,
    parameter int unsigned FAC_MAX  = 18021,
    parameter int unsigned FAC_STEP = 246
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] base_period,
    input  logic [CNT_W-1:0] duty_a,
    input  logic [CNT_W-1:0] duty_b,
    input  logic             jitter_en,
    output logic             gate_a,
    output logic             gate_b,
    output logic             trig_a,
    output logic             trig_b
);

    localparam int unsigned PW = CNT_W + 1;

    run_state_e state_q, state_d;

    logic [PW-1:0]                    per_q;
    logic [PW-1:0]                    cnt_q;
    logic [NUM_PHASES-1:0][PW-1:0]    duty_q;
    logic [NUM_PHASES-1:0][PW-1:0]    duty_lim;
    logic [NUM_PHASES-1:0][PW-1:0]    ph_cnt;
    logic [NUM_PHASES-1:0][CNT_W-1:0] duty_in;
    logic [NUM_PHASES-1:0]            gate_v;
    logic [NUM_PHASES-1:0]            trig_v;
    logic [PW-1:0]                    per_calc;
    logic                             per_ok;
    logic [FW-1:0]                    fac_q;
    logic [FW-1:0]                    fac_nxt;
    logic                             boundary;
    logic                             load;
    logic                             park;
    logic                             running;
    logic [PW:0]                      sum_b;

    // Period boundary and load events
    always_comb begin
        running  = (state_q == ST_RUN);
        park     = (state_q == ST_IDLE);
        boundary = running && (cnt_q == per_q - PW'(1));
        load     = park || boundary;
        duty_in  = {duty_b, duty_a};
    end

    ilv_jitter_gen #(
        .FW       (FW),
        .FAC_NOM  (FAC_NOM),
        .FAC_MIN  (FAC_MIN),
        .FAC_MAX  (FAC_MAX),
        .FAC_STEP (FAC_STEP)
    ) u_jitter (
        .clk     (clk),
        .rst_n   (rst_n),
        .park    (park),
        .adv     (boundary),
        .en      (jitter_en),
        .fac_nxt (fac_nxt),
        .fac     (fac_q)
    );

    ilv_period_calc #(
        .CNT_W   (CNT_W),
        .FW      (FW),
        .FRAC_SH (FRAC_SH)
    ) u_calc (
        .base     (base_period),
        .fac      (fac_nxt),
        .duty_in  (duty_in),
        .per      (per_calc),
        .duty_lim (duty_lim),
        .per_ok   (per_ok)
    );

    // Controller next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (per_ok)              state_d = ST_RUN;
            ST_RUN:  if (boundary && !per_ok) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter and shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q  <= '0;
            cnt_q  <= '0;
            duty_q <= '0;
        end else if (load && per_ok) begin
            per_q  <= per_calc;
            duty_q <= duty_lim;
            cnt_q  <= '0;
        end else if (running) begin
            cnt_q  <= cnt_q + PW'(1);
        end
    end

    // Phase B count, half a period ahead
    always_comb begin
        sum_b = {1'b0, cnt_q} + {1'b0, (per_q >> 1)};
        if (sum_b >= {1'b0, per_q}) begin
            sum_b = sum_b - {1'b0, per_q};
        end
        ph_cnt[0] = cnt_q;
        ph_cnt[1] = sum_b[PW-1:0];
    end

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        ilv_phase_out #(
            .PW (PW)
        ) u_phase (
            .run  (running),
            .cnt  (ph_cnt[p]),
            .duty (duty_q[p]),
            .gate (gate_v[p]),
            .trig (trig_v[p])
        );
    end

    // Outputs
    always_comb begin
        gate_a = gate_v[0];
        gate_b = gate_v[1];
        trig_a = trig_v[0];
        trig_b = trig_v[1];
    end

endmodule

// File: rtl/ilv_pwm_chk.sv
module ilv_pwm_chk #(
    parameter int unsigned PW      = 17,
    parameter int unsigned FW      = 16,
    parameter int unsigned FAC_MIN = 14745,
    parameter int unsigned FAC_MAX = 18021
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          boundary,
    input logic [PW-1:0] cnt,
    input logic [PW-1:0] per,
    input logic [FW-1:0] fac,
    input logic          gate_a,
    input logic          gate_b,
    input logic          trig_a,
    input logic          trig_b
);

    AST_FAC_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fac >= FW'(FAC_MIN)) && (fac <= FW'(FAC_MAX))); // R6

    AST_FAC_MOVES_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fac != $past(fac)) |-> ($past(boundary) || !$past(run))); // R6

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < per)); // R2

    AST_TRIG_A_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_a |=> !trig_a); // R4

    AST_TRIG_A_IN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        trig_a |-> gate_a); // R4

    AST_TRIG_B_IN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        trig_b |-> gate_b); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !(gate_a || gate_b || trig_a || trig_b)); // R11

endmodule

bind ilv_pwm_dither ilv_pwm_chk #(
    .PW      (PW),
    .FW      (FW),
    .FAC_MIN (FAC_MIN),
    .FAC_MAX (FAC_MAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (running),
    .boundary (boundary),
    .cnt      (cnt_q),
    .per      (per_q),
    .fac      (fac_q),
    .gate_a   (gate_a),
    .gate_b   (gate_b),
    .trig_a   (trig_a),
    .trig_b   (trig_b)
);

// File: tb/test_ilv_pwm_dither.sv
module test_ilv_pwm_dither;

    localparam int CLK_PERIOD = 10;
    localparam int NOM = 16384;
    localparam int FMIN = 14745;
    localparam int FMAX = 18021;
    localparam int FSTEP = 246;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] base_period = 16'd100;
    logic [15:0] duty_a = 16'd5;
    logic [15:0] duty_b = 16'd7;
    logic        jitter_en = 1'b0;
    logic        gate_a, gate_b, trig_a, trig_b;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench reference state
    int m_run = 0, m_per = 0, m_cnt = 0, m_da = 0, m_db = 0, m_fac = NOM, m_up = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_pwm_dither i_ilv_pwm_dither (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_period (base_period),
        .duty_a      (duty_a),
        .duty_b      (duty_b),
        .jitter_en   (jitter_en),
        .gate_a      (gate_a),
        .gate_b      (gate_b),
        .trig_a      (trig_a),
        .trig_b      (trig_b)
    );

    function automatic int exp_period(int base, int fac);
        longint prod;
        prod = longint'(base) * longint'(fac);
        return int'(prod >>> 14);
    endfunction

    function automatic int clampd(int d, int p);
        return (d >= p) ? p - 1 : d;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        int nf, nup, e;
        bit bnd;
        if (!rst_n) begin
            m_run = 0; m_per = 0; m_cnt = 0; m_da = 0; m_db = 0; m_fac = NOM; m_up = 1;
        end else begin
            bnd = (m_run != 0) && (m_cnt == m_per - 1);
            nf = m_fac;
            nup = m_up;
            if (m_run == 0) begin
                nf = NOM; nup = 1;
            end else if (bnd) begin
                if (!jitter_en) begin
                    nf = NOM; nup = 1;
                end else if (m_up != 0) begin
                    if (m_fac + FSTEP >= FMAX) begin nf = FMAX; nup = 0; end
                    else nf = m_fac + FSTEP;
                end else begin
                    if (m_fac <= FMIN + FSTEP) begin nf = FMIN; nup = 1; end
                    else nf = m_fac - FSTEP;
                end
            end
            if (m_run == 0 || bnd) begin
                e = exp_period(int'(base_period), nf);
                if (e >= 2) begin
                    m_run = 1; m_per = e; m_cnt = 0;
                    m_da = clampd(int'(duty_a), e);
                    m_db = clampd(int'(duty_b), e);
                end else begin
                    m_run = 0;
                end
            end else begin
                m_cnt++;
            end
            m_fac = nf;
            m_up = nup;
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        int cb, ega, egb, eta, etb;
        if (m_per > 0) cb = (m_cnt + m_per / 2) % m_per; else cb = 0;
        ega = (m_run != 0 && m_cnt < m_da) ? 1 : 0;
        egb = (m_run != 0 && cb < m_db) ? 1 : 0;
        eta = (m_run != 0 && m_da != 0 && m_cnt == m_da / 2) ? 1 : 0;
        etb = (m_run != 0 && m_db != 0 && cb == m_db / 2) ? 1 : 0;
        chk("R2 gate_a", int'(gate_a), ega);
        chk("R3 gate_b", int'(gate_b), egb);
        chk("R4 trig_a", int'(trig_a), eta);
        chk("R4 trig_b", int'(trig_b), etb);
    end

    task automatic wait_rise();
        logic pv, hit;
        pv = gate_a;
        hit = 1'b0;
        while (!hit) begin
            @(negedge clk);
            hit = !pv && gate_a;
            pv = gate_a;
        end
    endtask

    // Called on the cycle where gate_a just rose; returns length of that period
    task automatic measure(output int p);
        logic pv, hit;
        pv = gate_a;
        hit = 1'b0;
        p = 0;
        while (!hit) begin
            @(negedge clk);
            p++;
            hit = !pv && gate_a;
            pv = gate_a;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int p, pmin, pmax, n, lows, trg, act;
        void'($urandom(32'd4711));

        // R1: outputs quiet under reset and on the first cycle after it
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", int'({gate_a, gate_b, trig_a, trig_b}), 0);
        rst_n = 1'b1;
        chk("R1 outputs after release", int'({gate_a, gate_b, trig_a, trig_b}), 0);

        // R7 then R5: nominal period, then first dithered periods
        wait_rise();
        jitter_en = 1'b1;
        measure(p);
        chk("R7 nominal period", p, 100);
        measure(p);
        chk("R5 first dithered period", p, exp_period(100, 16630));
        measure(p);
        chk("R5 second dithered period", p, exp_period(100, 16876));

        // R6: full triangle sweep stays inside limits and reaches both ends
        pmin = 1000;
        pmax = 0;
        for (int i = 0; i < 40; i++) begin
            measure(p);
            chk("R6 period within dither range",
                (p >= exp_period(100, FMIN) && p <= exp_period(100, FMAX)) ? 1 : 0, 1);
            if (p < pmin) pmin = p;
            if (p > pmax) pmax = p;
        end
        chk("R6 longest period", pmax, exp_period(100, FMAX));
        chk("R6 shortest period", pmin, exp_period(100, FMIN));

        // R7: disabling dither restores the nominal period next time
        wait_rise();
        jitter_en = 1'b0;
        measure(p);
        measure(p);
        chk("R7 period after disable", p, 100);

        // R8: duty changed mid-period takes effect one period later
        base_period = 16'd20;
        duty_a = 16'd10;
        repeat (250) @(negedge clk);
        wait_rise();
        duty_a = 16'd2;
        n = 0;
        while (gate_a) begin n++; @(negedge clk); end
        chk("R8 on-time kept until boundary", n, 10);
        wait_rise();
        n = 0;
        while (gate_a) begin n++; @(negedge clk); end
        chk("R8 new on-time after boundary", n, 2);

        // R9: zero duty gives no pulse and no strobe
        duty_a = 16'd0;
        repeat (45) @(negedge clk);
        n = 0;
        trg = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n += int'(gate_a);
            trg += int'(trig_a);
        end
        chk("R9 gate_a highs at zero duty", n, 0);
        chk("R9 trig_a pulses at zero duty", trg, 0);

        // R10: oversized duty limited to P-1
        duty_a = 16'hFFFF;
        repeat (45) @(negedge clk);
        lows = 0;
        trg = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            lows += int'(!gate_a);
            trg += int'(trig_a);
        end
        chk("R10 low cycles per period", lows, 1);
        chk("R10 strobes per period", trg, 1);

        // R11: scaled period below 2 parks the block
        base_period = 16'd1;
        repeat (30) @(negedge clk);
        act = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            act += int'(gate_a | gate_b | trig_a | trig_b);
        end
        chk("R11 outputs while parked", act, 0);
        base_period = 16'd20;
        duty_a = 16'd6;
        repeat (5) @(negedge clk);
        chk("R11 resumed after period restored", int'(gate_a | gate_b), 1);

        // Random mix against the reference model
        for (int i = 0; i < 400; i++) begin
            base_period = 16'($urandom_range(0, 60));
            duty_a = 16'($urandom_range(0, 64));
            duty_b = 16'($urandom_range(0, 64));
            jitter_en = 1'($urandom_range(0, 1));
            repeat ($urandom_range(1, 25)) @(negedge clk);
        end

        repeat (5) @(negedge clk);
        report();
    end

endmodule